// File: doc/BRIEF.md
# Indirect Register Access Controller

This block sits behind a four-slot host register window and opens a 9-bit internal address space through it. Three memories (data memory, low connection memory and high connection memory) and a bank of control registers all live in that space. The host first loads a low address byte, then a mode byte. The mode byte carries the top pointer bit, the target select and an auto-step mode. From then on, every read or write of the data slot makes one transfer to or from the selected memory at the pointer. The pointer can step up or down after each transfer, so a burst of consecutive locations needs no further address writes.

Transfers go out on a request/acknowledge memory port. The host is told, through a slow flag, that its access is stretched until the memory answers. After reset the block sweeps all 512 locations and writes zero through a broadcast clear. Host data-slot accesses that arrive during this sweep are held, and they go out once the sweep ends.

Top module: `indirect_access_ctrl`

## Requirements
- R1: After reset the pointer, target and step fields read as zero, and the block issues clear writes (mem_clr, mem_we, data 0) to addresses 0 through 511 in ascending order, one per acknowledge, before any host transfer.
- R2: A host write to slot 1 sets pointer bits [7:0]; a read of slot 1 returns them.
- R3: Slot 2 layout: bit 0 is pointer bit 8, bits [2:1] the target (00 data memory, 01 low connection, 10 high connection, 11 control registers), bits [4:3] the step mode; bits [7:5] read as zero.
- R4: A host write to slot 3 raises mem_req with mem_we, mem_addr equal to the pointer, mem_sel equal to the target and mem_wdata equal to the written byte, all held until mem_ack; host_slow is high from the cycle after the strobe until completion.
- R5: A host read of slot 3 returns on host_rdata the mem_rdata sampled with mem_ack, with host_done high in the next cycle and host_slow low.
- R6: After each data-slot transfer the pointer steps by mode: 01 adds one, 10 subtracts one, both wrapping modulo 512; 00 and 11 leave it unchanged; the result reads back through slots 1 and 2.
- R7: Accesses to slots 0, 1 and 2 complete with host_done in the cycle after the strobe, without raising host_slow.
- R8: A data-slot access that arrives during the clearing sweep keeps host_slow high, is issued after the last clear (including when it arrives in the same cycle as the last clear's acknowledge), and then completes normally.
- R9: Any host strobe that arrives while host_slow is high is ignored: it produces no host_done and changes no register.
- R10: Slot 0 reads as zero, and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| host_cs | input | 1 | Host select, qualifies the strobes |
| host_rd | input | 1 | Read strobe, one cycle |
| host_wr | input | 1 | Write strobe, one cycle (wins over read) |
| host_slot | input | 2 | Register slot: 0 reserved, 1 low address, 2 mode, 3 data |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Read result, valid with host_done |
| host_done | output | 1 | Access complete, one-cycle pulse |
| host_slow | output | 1 | Access stretched, host must wait |
| mem_req | output | 1 | Memory cycle request |
| mem_we | output | 1 | Memory cycle is a write |
| mem_clr | output | 1 | Broadcast clear of all targets at mem_addr |
| mem_sel | output | 2 | Target memory select |
| mem_addr | output | 9 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_ack | input | 1 | Memory cycle done |
| mem_rdata | input | 8 | Memory read data, valid with mem_ack |

## Verification
Two events can meet in one cycle: the acknowledge of the final clear at address 511, and a host strobe on the data slot. The bench resets a second time and watches its memory model until the last clear's acknowledge is visible. It then drives the data-slot write so that the strobe is sampled on that same edge. The run passes only if host_slow stays high, the transfer is issued, host_done follows, and the byte lands at the pointer in the chosen target. A second case places the strobe in mid-sweep and confirms that all 512 clears came first.

// File: rtl/iac_pkg.sv
package iac_pkg;
    typedef enum logic [1:0] {
        SLOT_RSVD = 2'd0,
        SLOT_LOW  = 2'd1,
        SLOT_MODE = 2'd2,
        SLOT_DATA = 2'd3
    } slot_e;

    typedef enum logic [1:0] {
        STEP_NONE = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2,
        STEP_RSVD = 2'd3
    } step_e;

    typedef enum logic [1:0] {
        ST_SWEEP = 2'd0,
        ST_IDLE  = 2'd1,
        ST_XFER  = 2'd2
    } state_e;
endpackage

// File: rtl/iac_ptr_step.sv
module iac_ptr_step
    import iac_pkg::*;
#(
    parameter int ADDR_W = 9
) (
    input  logic [ADDR_W-1:0] ptr_i,
    input  logic [1:0]        step_i,
    output logic [ADDR_W-1:0] ptr_o
);
    // wraps naturally in ADDR_W bits
    always_comb begin
        case (step_e'(step_i))
            STEP_UP:   ptr_o = ptr_i + ADDR_W'(1);
            STEP_DOWN: ptr_o = ptr_i - ADDR_W'(1);
            default:   ptr_o = ptr_i;
        endcase
    end
endmodule

// File: rtl/iac_reg_rdmux.sv
module iac_reg_rdmux
    import iac_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int DATA_W = 8
) (
    input  logic [1:0]        slot_i,
    input  logic [ADDR_W-1:0] ptr_i,
    input  logic [1:0]        tgt_i,
    input  logic [1:0]        step_i,
    output logic [DATA_W-1:0] rd_o
);
    localparam int HI_W = ADDR_W - 8;
    localparam int PAD  = DATA_W - HI_W - 4;

    always_comb begin
        case (slot_e'(slot_i))
            SLOT_LOW:  rd_o = DATA_W'(ptr_i[7:0]);
            SLOT_MODE: rd_o = {{PAD{1'b0}}, step_i, tgt_i, ptr_i[ADDR_W-1:8]};
            default:   rd_o = '0;
        endcase
    end
endmodule

// File: rtl/indirect_access_ctrl.sv
module indirect_access_ctrl
    import iac_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_cs,
    input  logic              host_rd,
    input  logic              host_wr,
    input  logic [1:0]        host_slot,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_done,
    output logic              host_slow,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_clr,
    output logic [1:0]        mem_sel,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata
);
    localparam int              HI_W = ADDR_W - 8;
    localparam logic [ADDR_W-1:0] LAST = {ADDR_W{1'b1}};

    typedef struct packed {
        state_e            st;
        logic              pend;
        logic [ADDR_W-1:0] ptr;
        logic [1:0]        tgt;
        logic [1:0]        step;
        logic [ADDR_W-1:0] swp;
        logic              xwe;
        logic [DATA_W-1:0] xdata;
        logic [DATA_W-1:0] rdata;
        logic              done;
    } regs_t;

    regs_t q, d;

    logic [ADDR_W-1:0] ptr_nxt;
    logic [DATA_W-1:0] reg_rd;
    logic              strobe;
    logic              slow;

    iac_ptr_step #(.ADDR_W(ADDR_W)) u_step (
        .ptr_i  (q.ptr),
        .step_i (q.step),
        .ptr_o  (ptr_nxt)
    );

    iac_reg_rdmux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rdmux (
        .slot_i (host_slot),
        .ptr_i  (q.ptr),
        .tgt_i  (q.tgt),
        .step_i (q.step),
        .rd_o   (reg_rd)
    );

    assign strobe = host_cs && (host_rd || host_wr);
    assign slow   = (q.st == ST_XFER) || q.pend;

    always_comb begin
        d      = q;
        d.done = 1'b0;

        // memory side progress
        case (q.st)
            ST_SWEEP: begin
                if (mem_ack) begin
                    if (q.swp == LAST) begin
                        d.st   = q.pend ? ST_XFER : ST_IDLE;
                        d.pend = 1'b0;
                    end else begin
                        d.swp = q.swp + ADDR_W'(1);
                    end
                end
            end
            ST_XFER: begin
                if (mem_ack) begin
                    if (!q.xwe) d.rdata = mem_rdata;
                    d.done = 1'b1;
                    d.ptr  = ptr_nxt;
                    d.st   = ST_IDLE;
                end
            end
            default: ;
        endcase

        // host side; ignored while a transfer is outstanding
        if (strobe && !slow) begin
            case (slot_e'(host_slot))
                SLOT_LOW: begin
                    if (host_wr) d.ptr[7:0] = host_wdata[7:0];
                    else         d.rdata    = reg_rd;
                    d.done = 1'b1;
                end
                SLOT_MODE: begin
                    if (host_wr) begin
                        d.ptr[ADDR_W-1:8] = host_wdata[HI_W-1:0];
                        d.tgt             = host_wdata[HI_W+1:HI_W];
                        d.step            = host_wdata[HI_W+3:HI_W+2];
                    end else begin
                        d.rdata = reg_rd;
                    end
                    d.done = 1'b1;
                end
                SLOT_DATA: begin
                    d.xwe   = host_wr;
                    d.xdata = host_wdata;
                    // d.st already reflects a sweep ending this cycle
                    if (d.st == ST_SWEEP) d.pend = 1'b1;
                    else                  d.st   = ST_XFER;
                end
                default: begin
                    if (!host_wr) d.rdata = '0;
                    d.done = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign host_rdata = q.rdata;
    assign host_done  = q.done;
    assign host_slow  = slow;
    assign mem_req    = (q.st != ST_IDLE);
    assign mem_clr    = (q.st == ST_SWEEP);
    assign mem_we     = (q.st == ST_SWEEP) || q.xwe;
    assign mem_sel    = (q.st == ST_SWEEP) ? 2'b00 : q.tgt;
    assign mem_addr   = (q.st == ST_SWEEP) ? q.swp : q.ptr;
    assign mem_wdata  = (q.st == ST_SWEEP) ? '0 : q.xdata;
endmodule

// File: rtl/iac_checker.sv
module iac_checker #(
    parameter int ADDR_W = 9,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_cs,
    input logic              host_rd,
    input logic              host_wr,
    input logic [1:0]        host_slot,
    input logic              host_done,
    input logic              host_slow,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_clr,
    input logic [1:0]        mem_sel,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              mem_ack
);
    assert_clear_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_clr |-> (mem_req && mem_we && mem_wdata == '0));

    assert_clear_order_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_clr && mem_ack && mem_addr != {ADDR_W{1'b1}})
            |=> (mem_clr && mem_addr == $past(mem_addr) + ADDR_W'(1)));

    assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack)
            |=> (mem_req && $stable(mem_addr) && $stable(mem_sel) && $stable(mem_we)));

    assert_slow_during_xfer_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_clr) |-> host_slow);

    assert_done_after_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_clr && mem_ack) |=> (host_done && !host_slow && !mem_req));

    assert_fast_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (host_cs && (host_rd || host_wr) && host_slot != 2'd3 && !host_slow) |=> host_done);

    assert_ignored_while_slow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (host_slow && !mem_ack) |=> !host_done);
endmodule

bind indirect_access_ctrl iac_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_cs   (host_cs),
    .host_rd   (host_rd),
    .host_wr   (host_wr),
    .host_slot (host_slot),
    .host_done (host_done),
    .host_slow (host_slow),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_clr   (mem_clr),
    .mem_sel   (mem_sel),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ack   (mem_ack)
);

// File: tb/indirect_access_ctrl_tb.sv
module indirect_access_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_cs = 1'b0, host_rd = 1'b0, host_wr = 1'b0;
    logic [1:0] host_slot = 2'd0;
    logic [7:0] host_wdata = 8'd0;
    logic [7:0] host_rdata;
    logic       host_done, host_slow;
    logic       mem_req, mem_we, mem_clr, mem_ack;
    logic [1:0] mem_sel;
    logic [8:0] mem_addr;
    logic [7:0] mem_wdata, mem_rdata;

    always #10 clk = ~clk;

    indirect_access_ctrl u_dut (
        .clk(clk), .rst_n(rst_n),
        .host_cs(host_cs), .host_rd(host_rd), .host_wr(host_wr),
        .host_slot(host_slot), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .host_done(host_done), .host_slow(host_slow),
        .mem_req(mem_req), .mem_we(mem_we), .mem_clr(mem_clr), .mem_sel(mem_sel),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    int n_chk = 0, n_bad = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // behavioural backing memory, garbage-filled during reset
    logic [7:0] ram [4][512];
    logic       ack_q;
    int         clr_cnt, clr_err;

    always @(posedge clk) begin
        if (!rst_n) begin
            ack_q   <= 1'b0;
            clr_cnt <= 0;
            clr_err <= 0;
            for (int s = 0; s < 4; s++)
                for (int a = 0; a < 512; a++)
                    ram[s][a] <= 8'((a * 7 + s * 53) | 1);
        end else begin
            ack_q <= mem_req && !ack_q;
            if (mem_req && ack_q) begin
                if (mem_clr) begin
                    for (int s = 0; s < 4; s++) ram[s][mem_addr] <= 8'h00;
                    if (int'(mem_addr) != clr_cnt) clr_err <= clr_err + 1;
                    clr_cnt <= clr_cnt + 1;
                end else if (mem_we) begin
                    ram[mem_sel][mem_addr] <= mem_wdata;
                end
            end
        end
    end
    assign mem_ack   = ack_q;
    assign mem_rdata = ram[mem_sel][mem_addr];

    // reference model from the requirements
    logic [8:0] ref_ptr;
    logic [1:0] ref_tgt, ref_step;
    logic [7:0] shadow [4][512];

    function automatic logic [8:0] step_fn(input logic [8:0] p, input logic [1:0] m);
        case (m)
            2'd1:    return p + 9'd1;
            2'd2:    return p - 9'd1;
            default: return p;
        endcase
    endfunction

    typedef struct packed { logic rd; logic [7:0] val; } exp_t;
    exp_t  sb_q[$];
    string tag_q[$];

    // monitor: pops one expected item per completion
    always @(negedge clk) begin
        if (rst_n && host_done) begin
            if (sb_q.size() == 0) begin
                chk(1'b0, "R9 unexpected done", 1, 0);
            end else begin
                exp_t  e;
                string t;
                e = sb_q.pop_front();
                t = tag_q.pop_front();
                if (e.rd) chk(host_rdata == e.val, t, host_rdata, e.val);
                else      chk(1'b1, t, 0, 0);
            end
        end
    end

    task automatic do_reset();
        rst_n = 1'b0; host_cs = 0; host_rd = 0; host_wr = 0;
        repeat (4) @(negedge clk);
        ref_ptr = '0; ref_tgt = '0; ref_step = '0;
        for (int s = 0; s < 4; s++)
            for (int a = 0; a < 512; a++) shadow[s][a] = 8'h00;
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // update reference and push expectation for one accepted access
    task automatic model_push(input logic [1:0] slot, input bit wr, input logic [7:0] data,
                              input string tag);
        exp_t e;
        e.rd = !wr; e.val = 8'h00;
        case (slot)
            2'd1: if (wr) ref_ptr[7:0] = data; else e.val = ref_ptr[7:0];
            2'd2: if (wr) begin
                      ref_ptr[8] = data[0]; ref_tgt = data[2:1]; ref_step = data[4:3];
                  end else e.val = {3'b000, ref_step, ref_tgt, ref_ptr[8]};
            2'd3: begin
                      if (wr) shadow[ref_tgt][ref_ptr] = data;
                      else    e.val = shadow[ref_tgt][ref_ptr];
                      ref_ptr = step_fn(ref_ptr, ref_step);
                  end
            default: ;
        endcase
        sb_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    task automatic drive(input logic [1:0] slot, input bit wr, input logic [7:0] data);
        host_cs = 1'b1; host_wr = wr; host_rd = !wr; host_slot = slot; host_wdata = data;
    endtask

    task automatic release_bus();
        host_cs = 1'b0; host_wr = 1'b0; host_rd = 1'b0;
    endtask

    task automatic acc(input logic [1:0] slot, input bit wr, input logic [7:0] data,
                       input string tag);
        logic [8:0] a;
        logic [1:0] t;
        while (host_slow) @(negedge clk);
        a = ref_ptr; t = ref_tgt;
        model_push(slot, wr, data, tag);
        drive(slot, wr, data);
        @(negedge clk);
        release_bus();
        if (slot != 2'd3) chk(host_done && !host_slow, "R7 fast completion",
                              {host_done, host_slow}, 2);
        else              chk(host_slow, "R4 slow flag raised", host_slow, 1);
        while (!host_done) @(negedge clk);
        if (slot == 2'd3 && wr) chk(ram[t][a] == data, "R4 byte at pointer", ram[t][a], data);
        @(negedge clk);
    endtask

    initial begin : watchdog
        int cyc = 0;
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                chk(1'b0, "watchdog expired", cyc, 150000);
                $display("test done: total=%0d bad=%0d", n_chk, n_bad);
                $finish;
            end
        end
    end

    initial begin : main
        int nz;
        do_reset();

        // R1: register reset values, read while sweep is running
        repeat (5) @(negedge clk);
        chk(mem_clr && mem_req, "R1 sweep active", mem_clr, 1);
        acc(2'd1, 0, 8'h00, "R1 low address reset");
        acc(2'd2, 0, 8'h00, "R1 mode reset");
        acc(2'd0, 0, 8'h00, "R10 reserved read");

        // R8: data-slot write issued mid-sweep
        acc(2'd1, 1, 8'h05, "R2 low write");
        acc(2'd2, 1, 8'h0A, "R3 mode write");   // tgt 01, step up
        acc(2'd3, 1, 8'hA5, "R8 stalled write");
        chk(clr_cnt == 512, "R8 sweep finished first", clr_cnt, 512);
        chk(clr_err == 0, "R1 ascending clear order", clr_err, 0);
        nz = 0;
        for (int s = 0; s < 4; s++)
            for (int a = 0; a < 512; a++) if (ram[s][a] != 8'h00) nz++;
        chk(nz == 1, "R1 memories cleared", nz, 1);
        acc(2'd1, 0, 8'h00, "R6 step after write");  // expects 06

        // R2, R3
        acc(2'd1, 1, 8'h3C, "R2 low write");
        acc(2'd1, 0, 8'h00, "R2 low readback");
        acc(2'd2, 1, 8'hFF, "R3 mode write all ones");
        acc(2'd2, 0, 8'h00, "R3 upper bits zero");

        // R4, R5: each target, no stepping
        for (int t = 0; t < 4; t++) begin
            acc(2'd1, 1, 8'(8'h10 + t), "R2 low write");
            acc(2'd2, 1, 8'({t[1:0], 1'b1}), "R3 mode write"); // ptr8=1
            acc(2'd3, 1, 8'(8'hC0 + t * 5), "R4 target write");
        end
        for (int t = 0; t < 4; t++) begin
            acc(2'd1, 1, 8'(8'h10 + t), "R2 low write");
            acc(2'd2, 1, 8'({t[1:0], 1'b1}), "R3 mode write");
            acc(2'd3, 0, 8'h00, "R5 target read");
            acc(2'd2, 1, 8'({~t[1:0], 1'b1}), "R3 mode write");
            acc(2'd3, 0, 8'h00, "R5 other target read");
        end

        // R6: increment across the top, wrap to zero
        acc(2'd1, 1, 8'hFE, "R2 low write");
        acc(2'd2, 1, 8'h09, "R3 mode write");   // ptr8=1 tgt 00 step up
        acc(2'd3, 1, 8'h11, "R6 inc write 1FE");
        acc(2'd3, 1, 8'h22, "R6 inc write 1FF");
        acc(2'd3, 1, 8'h33, "R6 inc write 000");
        acc(2'd1, 0, 8'h00, "R6 wrapped low");
        acc(2'd2, 0, 8'h00, "R6 wrapped mode");
        // decrement across zero
        acc(2'd1, 1, 8'h00, "R2 low write");
        acc(2'd2, 1, 8'h10, "R3 mode write");   // ptr8=0 tgt 00 step down
        acc(2'd3, 0, 8'h00, "R6 dec read 000");
        acc(2'd3, 0, 8'h00, "R6 dec read 1FF");
        acc(2'd3, 0, 8'h00, "R6 dec read 1FE");
        acc(2'd1, 0, 8'h00, "R6 dec low");
        // reserved mode holds
        acc(2'd2, 1, 8'h18, "R3 mode write");   // step 11
        acc(2'd3, 1, 8'h44, "R6 reserved write");
        acc(2'd3, 0, 8'h00, "R6 reserved read same");
        acc(2'd1, 0, 8'h00, "R6 reserved low");

        // R10: reserved slot write has no effect
        acc(2'd1, 1, 8'h40, "R2 low write");
        acc(2'd2, 1, 8'h04, "R3 mode write");   // tgt 10, no step
        acc(2'd0, 1, 8'h77, "R10 reserved write");
        acc(2'd0, 0, 8'h00, "R10 reserved read");
        acc(2'd1, 0, 8'h00, "R10 low untouched");
        acc(2'd2, 0, 8'h00, "R10 mode untouched");

        // R9: strobe while slow is dropped
        model_push(2'd3, 1, 8'h5C, "R9 real write");
        drive(2'd3, 1, 8'h5C);
        @(negedge clk);
        drive(2'd1, 1, 8'h99);
        chk(host_slow, "R9 slow while second strobe", host_slow, 1);
        @(negedge clk);
        release_bus();
        chk(!host_done, "R9 no completion for dropped strobe", host_done, 0);
        while (!host_done) @(negedge clk);
        @(negedge clk);
        acc(2'd1, 0, 8'h00, "R9 low unchanged");

        // R8 collision: strobe sampled with the last clear acknowledge
        do_reset();
        acc(2'd1, 1, 8'h21, "R2 low write");
        acc(2'd2, 1, 8'h04, "R3 mode write");
        while (!(mem_clr && mem_addr == 9'h1FF && ack_q)) @(negedge clk);
        model_push(2'd3, 1, 8'h5A, "R8 collision write");
        drive(2'd3, 1, 8'h5A);
        @(negedge clk);
        release_bus();
        chk(host_slow && !mem_clr, "R8 collision accepted", {host_slow, mem_clr}, 2);
        while (!host_done) @(negedge clk);
        chk(ram[2][9'h021] == 8'h5A, "R8 collision byte stored", ram[2][9'h021], 8'h5A);
        chk(clr_cnt == 512, "R1 full sweep again", clr_cnt, 512);
        @(negedge clk);
        acc(2'd3, 0, 8'h00, "R8 collision readback");

        repeat (3) @(negedge clk);
        chk(sb_q.size() == 0, "R5 all completions seen", sb_q.size(), 0);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule